// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a 64-bit effective address into a real address by walking a radix translation tree held in memory. A request carries the effective address, a 32-bit process identifier and a 64-bit table-pointer register. The walker first reads the process-table entry selected by the identifier. From that entry it takes the size of the translation tree, the index width of the root directory and the base of the root directory.

Before the first directory lookup, the walker checks that the address lies inside the tree and that the root index width makes sense. It then reads directory entries one level at a time through a 64-bit read port that uses a valid/ready handshake. The walk ends in a leaf, which produces the real address, or in a fault. Every address the walker forms is built by merging two sources under a mask whose low `n` bits are ones.

Bit numbers below count from the least significant bit (bit 63 is the MSB). Status codes on `status`: 0 success, 1 segment fault, 2 bad tree, 3 missing entry. Codes 4 (permission) and 5 (reference/change) are reserved and never produced.

Top module: `radix_walker`

## Requirements
- R1: After reset, and whenever the walker is idle, `reqReady` is 1, `rdValid` is 0 and `done` is 0.
- R2: When effective-address bit 63 is 1, the process identifier used for indexing is zero, whatever `reqPid` holds.
- R3: The first read is at {8'h00, tbl[55:36], F, p[7:0], 4'h0}. Here p is the effective identifier, tbl is `reqTableReg`, and F is 24 bits that take tbl[35:12] where the mask of tbl[4:0] ones is 0 and p[31:8] where it is 1.
- R4: Let T = {e[7:5], e[62:61]} be the tree size taken from the process entry e. If address bits 63 and 62 differ, or any of address bits 61:31 is 1 where the T-bit mask is 0, the walk ends with status 1 and makes no directory read.
- R5: Let m = e[4:0] be the root index width. If m < 5, m > 16 or m > T+19, the walk ends with status 2 and makes no directory read. Otherwise the shift becomes S = T+19-m.
- R6: A directory read is at {8'h00, B[55:19], (B[18:3] masked out) merged with the low 16 bits of (addr[59:12] >> S) under the m-bit mask, 3'b000}. B is the root base {e[55:8], 16'h0}, or {8'h00, d[55:8], 8'h00} for the next level below a directory entry d.
- R7: A directory entry with bit 63 (valid) clear ends the walk with status 3.
- R8: In a non-leaf entry (bit 62 clear), let n = d[4:0] be the next-level index width. If n < 5, n > 16 or n > S, the walk ends with status 2. Otherwise S becomes S-n and m becomes n.
- R9: A leaf entry (bits 63 and 62 set) ends the walk with status 0. The real address is {8'h00, bits 55:12 taken from the entry where the S-bit mask is 0 and from the address where it is 1, entry bits 11:0}.
- R10: `done` is high for exactly one cycle per accepted request. `reqReady` stays low from acceptance until after `done`, and requests offered while the walker is busy have no effect on the result.
- R11: `rdValid` and `rdAddr` hold steady until `rdReady` is seen. After a handshake, no new read is issued until `rdDataValid` has returned the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Walk request offered |
| reqReady | output | 1 | Walker idle, request accepted on this edge |
| reqAddr | input | 64 | Effective address to translate |
| reqPid | input | 32 | Process identifier |
| reqTableReg | input | 64 | Process-table base (bits 55:12) and size (bits 4:0) |
| rdValid | output | 1 | Memory read request |
| rdAddr | output | 64 | Memory read byte address |
| rdReady | input | 1 | Memory accepts the read |
| rdDataValid | input | 1 | Read data returned this cycle |
| rdData | input | 64 | Read data |
| done | output | 1 | One-cycle walk completion pulse |
| status | output | 3 | Completion code |
| realAddr | output | 64 | Translated address, meaningful when status is 0 |

## Verification
The assertions assume that the memory side keeps to its handshake. It returns exactly one `rdDataValid` pulse for each accepted read, and never pulses while no read is outstanding. The bench responder meets this by granting `rdReady` only while `rdValid` is high and no reply is pending, and by answering after one to three cycles. Trees are built by the bench around a random address, pointer register and identifier. Random fault injection then moves the address out of its segment, corrupts the root or next-level index widths, or leaves an entry missing. Every walk's read sequence, status and result are compared with a model in the bench.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;
  localparam int VA_W    = 64;
  localparam int PID_W   = 32;
  localparam int SHIFT_W = 6;
  localparam int IDX_W   = 5;
  localparam int IDX_MIN = 5;
  localparam int IDX_MAX = 16;
  localparam int ROOT_ADJ = 19;

  typedef enum logic [2:0] {
    WALK_OK      = 3'd0,
    WALK_SEGERR  = 3'd1,
    WALK_BADTREE = 3'd2,
    WALK_NOPTE   = 3'd3,
    WALK_PERM    = 3'd4,
    WALK_RC      = 3'd5
  } walkStatus_e;

  typedef struct packed {
    logic capture;
    logic takeRoot;
    logic applyRoot;
    logic formPde;
    logic takeNext;
    logic takeLeaf;
  } walkStrobe_t;

  typedef struct packed {
    logic segErr;
    logic rootBad;
    logic pdeValid;
    logic pdeLeaf;
    logic nextBad;
  } walkFlags_t;

  function automatic logic [VA_W-1:0] genMask(input logic [SHIFT_W-1:0] n);
    logic [VA_W-1:0] m;
    for (int i = 0; i < VA_W; i++) m[i] = (SHIFT_W'(i) < n);
    return m;
  endfunction
endpackage

// File: rtl/radix_walk_dp.sv
module radix_walk_dp
  import radix_walk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  walkStrobe_t      strobe,
  input  logic [VA_W-1:0]  reqAddr,
  input  logic [PID_W-1:0] reqPid,
  input  logic [VA_W-1:0]  reqTableReg,
  input  logic [VA_W-1:0]  rdData,
  output logic [VA_W-1:0]  rdAddr,
  output logic [VA_W-1:0]  realAddr,
  output walkFlags_t       flags
);
  logic [VA_W-1:0]    vaddrQ, rdAddrQ, pgbaseQ, realQ;
  logic [SHIFT_W-1:0] shiftQ;
  logic [IDX_W-1:0]   mbitsQ;

  logic [PID_W-1:0]   effPid;
  logic [VA_W-1:0]    tblMask, curMask, idxMaskFull, prteAddr, pdeAddr, leafAddr;
  logic [15:0]        idxMask;
  logic [47:0]        addrSh;
  logic [IDX_W-1:0]   nls;
  logic [SHIFT_W-1:0] rootShift;
  logic               unusedBits;

  always_comb begin
    effPid      = reqAddr[63] ? '0 : reqPid;
    tblMask     = genMask({1'b0, reqTableReg[4:0]});
    prteAddr    = {8'h00, reqTableReg[55:36],
                   (reqTableReg[35:12] & ~tblMask[23:0]) | (effPid[31:8] & tblMask[23:0]),
                   effPid[7:0], 4'h0};
    curMask     = genMask(shiftQ);
    idxMaskFull = genMask({1'b0, mbitsQ});
    idxMask     = idxMaskFull[15:0];
    addrSh      = vaddrQ[59:12] >> shiftQ;
    pdeAddr     = {8'h00, pgbaseQ[55:19],
                   (pgbaseQ[18:3] & ~idxMask) | (addrSh[15:0] & idxMask), 3'b000};
    leafAddr    = {8'h00, (rdData[55:12] & ~curMask[43:0]) | (vaddrQ[55:12] & curMask[43:0]),
                   rdData[11:0]};
    nls         = rdData[4:0];
    rootShift   = {1'b0, rdData[7:5], rdData[62:61]};

    flags.segErr   = (vaddrQ[63] != vaddrQ[62]) || (|(vaddrQ[61:31] & ~curMask[30:0]));
    flags.rootBad  = (mbitsQ < IDX_W'(IDX_MIN)) || (mbitsQ > IDX_W'(IDX_MAX)) ||
                     ({2'b00, mbitsQ} > ({1'b0, shiftQ} + 7'(ROOT_ADJ)));
    flags.pdeValid = rdData[63];
    flags.pdeLeaf  = rdData[62];
    flags.nextBad  = (nls < IDX_W'(IDX_MIN)) || (nls > IDX_W'(IDX_MAX)) ||
                     ({1'b0, nls} > shiftQ);
  end

  assign unusedBits = ^{vaddrQ[11:0], reqTableReg[63:56], reqTableReg[11:5], rdData[60:56]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ  <= '0;
      rdAddrQ <= '0;
      pgbaseQ <= '0;
      realQ   <= '0;
      shiftQ  <= '0;
      mbitsQ  <= '0;
    end else begin
      if (strobe.capture) begin
        vaddrQ  <= reqAddr;
        rdAddrQ <= prteAddr;
      end
      if (strobe.takeRoot) begin
        shiftQ  <= rootShift;
        mbitsQ  <= rdData[4:0];
        pgbaseQ <= {rdData[55:8], 16'h0000};
      end
      if (strobe.applyRoot) shiftQ <= shiftQ + SHIFT_W'(ROOT_ADJ) - {1'b0, mbitsQ};
      if (strobe.formPde) rdAddrQ <= pdeAddr;
      if (strobe.takeNext) begin
        shiftQ  <= shiftQ - {1'b0, nls};
        mbitsQ  <= nls;
        pgbaseQ <= {8'h00, rdData[55:8], 8'h00};
      end
      if (strobe.takeLeaf) realQ <= leafAddr;
    end
  end

  assign rdAddr   = rdAddrQ;
  assign realAddr = realQ;
endmodule

// File: rtl/radix_walk_ctrl.sv
module radix_walk_ctrl
  import radix_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        rdReady,
  input  logic        rdDataValid,
  input  walkFlags_t  flags,
  output logic        reqReady,
  output logic        rdValid,
  output logic        done,
  output walkStatus_e status,
  output walkStrobe_t strobe
);
  typedef enum logic [2:0] {
    S_IDLE, S_PRT_RD, S_PRT_WAIT, S_SEG, S_PDE_ADDR, S_PDE_RD, S_PDE_WAIT, S_DONE
  } walkState_e;

  walkState_e  stateQ, stateD;
  walkStatus_e statusQ, finStatus;
  logic        finish;

  always_comb begin
    strobe    = '0;
    stateD    = stateQ;
    finish    = 1'b0;
    finStatus = WALK_OK;
    case (stateQ)
      S_IDLE: if (reqValid) begin
        strobe.capture = 1'b1;
        stateD = S_PRT_RD;
      end
      S_PRT_RD:   if (rdReady) stateD = S_PRT_WAIT;
      S_PRT_WAIT: if (rdDataValid) begin
        strobe.takeRoot = 1'b1;
        stateD = S_SEG;
      end
      S_SEG: begin
        if (flags.segErr) begin
          finish = 1'b1; finStatus = WALK_SEGERR;
        end else if (flags.rootBad) begin
          finish = 1'b1; finStatus = WALK_BADTREE;
        end else begin
          strobe.applyRoot = 1'b1;
          stateD = S_PDE_ADDR;
        end
      end
      S_PDE_ADDR: begin
        strobe.formPde = 1'b1;
        stateD = S_PDE_RD;
      end
      S_PDE_RD:   if (rdReady) stateD = S_PDE_WAIT;
      S_PDE_WAIT: if (rdDataValid) begin
        if (!flags.pdeValid) begin
          finish = 1'b1; finStatus = WALK_NOPTE;
        end else if (flags.pdeLeaf) begin
          strobe.takeLeaf = 1'b1;
          finish = 1'b1; finStatus = WALK_OK;
        end else if (flags.nextBad) begin
          finish = 1'b1; finStatus = WALK_BADTREE;
        end else begin
          strobe.takeNext = 1'b1;
          stateD = S_PDE_ADDR;
        end
      end
      S_DONE:  stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
    if (finish) stateD = S_DONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      statusQ <= WALK_OK;
    end else begin
      stateQ <= stateD;
      if (finish) statusQ <= finStatus;
    end
  end

  assign reqReady = (stateQ == S_IDLE);
  assign rdValid  = (stateQ == S_PRT_RD) || (stateQ == S_PDE_RD);
  assign done     = (stateQ == S_DONE);
  assign status   = statusQ;
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import radix_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [63:0] reqAddr,
  input  logic [31:0] reqPid,
  input  logic [63:0] reqTableReg,
  output logic        rdValid,
  output logic [63:0] rdAddr,
  input  logic        rdReady,
  input  logic        rdDataValid,
  input  logic [63:0] rdData,
  output logic        done,
  output logic [2:0]  status,
  output logic [63:0] realAddr
);
  walkStrobe_t strobe;
  walkFlags_t  flags;
  walkStatus_e statusE;

  radix_walk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rdReady(rdReady),
    .rdDataValid(rdDataValid), .flags(flags), .reqReady(reqReady),
    .rdValid(rdValid), .done(done), .status(statusE), .strobe(strobe)
  );

  radix_walk_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr), .reqPid(reqPid),
    .reqTableReg(reqTableReg), .rdData(rdData), .rdAddr(rdAddr),
    .realAddr(realAddr), .flags(flags)
  );

  assign status = statusE;
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        rdValid,
  input logic [63:0] rdAddr,
  input logic        rdReady,
  input logic        done,
  input logic [2:0]  status,
  input logic [63:0] realAddr
);
  assert_idle_no_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !rdValid);

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !rdReady |=> rdValid && $stable(rdAddr));

  assert_rd_drop_R11: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && rdReady |=> !rdValid);

  assert_status_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> status <= 3'd3);

  assert_real_top_R9: assert property (@(posedge clk) disable iff (!rstN)
    done && status == 3'd0 |-> realAddr[63:56] == 8'h00);
endmodule

bind radix_walker radix_walker_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rdValid(rdValid), .rdAddr(rdAddr), .rdReady(rdReady), .done(done),
  .status(status), .realAddr(realAddr)
);

// File: tb/radix_walker_bench.sv
module radix_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 300;

  logic        clk, rstN, reqValid, reqReady, rdValid, rdReady, rdDataValid, done;
  logic [63:0] reqAddr, reqTableReg, rdAddr, rdData, realAddr;
  logic [31:0] reqPid;
  logic [2:0]  status;

  int checks = 0;
  int errors = 0;

  radix_walker u_radix_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqPid(reqPid), .reqTableReg(reqTableReg),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdReady(rdReady),
    .rdDataValid(rdDataValid), .rdData(rdData), .done(done),
    .status(status), .realAddr(realAddr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] memArr [logic [63:0]];
  logic [63:0] gotAddrs[$];
  logic [63:0] expAddrs[$];
  logic [63:0] pendAddr;
  int          lat;

  function automatic logic [63:0] memRd(input logic [63:0] a);
    return memArr.exists(a) ? memArr[a] : 64'h0;
  endfunction

  function automatic logic [63:0] gmask(input int n);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = (i < n);
    return m;
  endfunction

  function automatic logic [63:0] prteAddrF(input logic [63:0] a, input logic [31:0] pid,
                                            input logic [63:0] tbl);
    logic [31:0] p;
    logic [63:0] fm;
    p  = a[63] ? 32'h0 : pid;
    fm = gmask(int'(tbl[4:0]));
    return {8'h00, tbl[55:36], (tbl[35:12] & ~fm[23:0]) | (p[31:8] & fm[23:0]), p[7:0], 4'h0};
  endfunction

  function automatic logic [63:0] pdeAddrF(input logic [63:0] base, input int mb,
                                           input int sh, input logic [63:0] a);
    logic [47:0] s;
    logic [63:0] m;
    s = a[59:12] >> sh;
    m = gmask(mb);
    return {8'h00, base[55:19], (base[18:3] & ~m[15:0]) | (s[15:0] & m[15:0]), 3'b000};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model of the walk, built from the requirements
  task automatic refWalk(input logic [63:0] a, input logic [31:0] pid, input logic [63:0] tbl,
                         output int st, output logic [63:0] ra, output string tag);
    logic [63:0] d, fm, base;
    int sh, mb, nls;
    expAddrs.delete();
    ra = 64'h0;
    expAddrs.push_back(prteAddrF(a, pid, tbl));
    d    = memRd(expAddrs[0]);
    sh   = int'({d[7:5], d[62:61]});
    mb   = int'(d[4:0]);
    base = {d[55:8], 16'h0};
    fm   = gmask(sh);
    if (a[63] != a[62] || (|(a[61:31] & ~fm[30:0]))) begin st = 1; tag = "R4"; return; end
    if (mb < 5 || mb > 16 || mb > sh + 19) begin st = 2; tag = "R5"; return; end
    sh = sh + 19 - mb;
    for (int lv = 0; lv < 8; lv++) begin
      expAddrs.push_back(pdeAddrF(base, mb, sh, a));
      d = memRd(expAddrs[expAddrs.size()-1]);
      if (!d[63]) begin st = 3; tag = "R7"; return; end
      if (d[62]) begin
        fm = gmask(sh);
        ra = {8'h00, (d[55:12] & ~fm[43:0]) | (a[55:12] & fm[43:0]), d[11:0]};
        st = 0; tag = "R9"; return;
      end
      nls = int'(d[4:0]);
      if (nls < 5 || nls > 16 || nls > sh) begin st = 2; tag = "R8"; return; end
      sh   = sh - nls;
      mb   = nls;
      base = {8'h00, d[55:8], 8'h00};
    end
    st = 3; tag = "R7";
  endtask

  // fault: 0 none, 4 segment, 5 bad root width, 6 missing entry, 7 bad next width
  task automatic buildTree(input logic [63:0] a, input logic [31:0] pid, input logic [63:0] tbl,
                           input int fault, input int leafLevel);
    logic [63:0] d, base;
    int sh, mb, nls, badLevel;
    memArr.delete();
    mb = (fault == 5) ? (($urandom % 2) ? 4 : 17) : 13;
    d = {$urandom, $urandom};
    d[63] = 1'b0; d[62:61] = 2'b01; d[7:5] = 3'b101; d[4:0] = 5'(mb);
    memArr[prteAddrF(a, pid, tbl)] = d;
    if (fault == 4 || fault == 5) return;
    base = {d[55:8], 16'h0};
    sh = 21 + 19 - mb;
    badLevel = ($urandom % 2) ? 0 : 3;
    for (int lv = 0; lv < 4; lv++) begin
      logic [63:0] adr;
      adr = pdeAddrF(base, mb, sh, a);
      if (fault == 7 && lv == badLevel) begin
        nls = (lv == 0) ? (($urandom % 2) ? 3 : 17) : 5;
        memArr[adr] = {2'b10, 6'h0, $urandom, 16'(~$urandom), 3'b000, 5'(nls)};
        return;
      end
      if (fault != 7 && lv == leafLevel) begin
        d = {$urandom, $urandom};
        d[63:62] = 2'b11;
        if (fault != 6) memArr[adr] = d;
        return;
      end
      nls = 9;
      d = {2'b10, 6'h0, $urandom, 16'($urandom), 3'b000, 5'(nls)};
      memArr[adr] = d;
      base = {8'h00, d[55:8], 8'h00};
      sh = sh - nls;
      mb = nls;
    end
  endtask

  // memory responder: grants on a negative edge, answers 1 to 3 cycles later
  initial begin
    rdReady = 1'b0; rdDataValid = 1'b0; rdData = '0; lat = 0; pendAddr = '0;
    forever begin
      @(negedge clk);
      rdDataValid = 1'b0;
      if (rdReady) begin
        rdReady = 1'b0;
        lat = 1 + int'($urandom % 3);
      end else if (lat > 0) begin
        lat--;
        if (lat == 0) begin rdDataValid = 1'b1; rdData = memRd(pendAddr); end
      end else if (rdValid && ($urandom % 2 == 0)) begin
        rdReady = 1'b1;
        pendAddr = rdAddr;
        gotAddrs.push_back(rdAddr);
      end
    end
  end

  task automatic runWalk(input logic [63:0] a, input logic [31:0] pid, input logic [63:0] tbl,
                         input bit poke);
    int st, n;
    logic [63:0] ra;
    string tag;
    refWalk(a, pid, tbl, st, ra, tag);
    gotAddrs.delete();
    @(negedge clk);
    reqAddr = a; reqPid = pid; reqTableReg = tbl; reqValid = 1'b1;
    @(negedge clk);
    if (poke) begin
      reqAddr = ~a; reqPid = pid ^ 32'h00ff_00ff; reqTableReg = tbl ^ 64'h0000_0fff_0000_f01f;
    end else reqValid = 1'b0;
    n = 0;
    while (!done && n < 600) begin @(negedge clk); n++; end
    reqValid = 1'b0;
    check(n < 600, "R10 walk timeout", 64'(n), 64'd600);
    check(status == 3'(st), poke ? "R10 busy request status" : tag, 64'(status), 64'(st));
    if (st == 0) check(realAddr == ra, poke ? "R10 busy request result" : "R9", realAddr, ra);
    check(gotAddrs.size() == expAddrs.size(), "R11 read count",
          64'(gotAddrs.size()), 64'(expAddrs.size()));
    for (int i = 0; i < expAddrs.size() && i < gotAddrs.size(); i++)
      check(gotAddrs[i] == expAddrs[i], i == 0 ? (a[63] ? "R2" : "R3") : "R6",
            gotAddrs[i], expAddrs[i]);
    @(negedge clk);
    check(done == 1'b0, "R10 done width", 64'(done), 64'd0);
    check(reqReady == 1'b1, "R10 ready after done", 64'(reqReady), 64'd1);
  endtask

  function automatic logic [63:0] randAddr(input bit upper);
    logic [63:0] a;
    a = {$urandom, $urandom};
    a[63:62] = upper ? 2'b11 : 2'b00;
    a[61:52] = '0;
    return a;
  endfunction

  function automatic logic [63:0] randTbl();
    logic [63:0] t;
    t = {$urandom, $urandom} & 64'h00ff_ffff_ffff_f000;
    t[4:0] = 5'($urandom % 8);
    return t;
  endfunction

  task automatic scenario(input int fault, input int leafLevel, input bit upper, input bit poke);
    logic [63:0] a, t;
    logic [31:0] pid;
    a = randAddr(upper);
    t = randTbl();
    pid = $urandom;
    if (fault == 4) begin
      if ($urandom % 2) a[62] = ~a[62];
      else a[52 + int'($urandom % 10)] = 1'b1;
    end
    buildTree(a, pid, t, fault, leafLevel);
    runWalk(a, pid, t, poke);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqPid = '0; reqTableReg = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 reqReady", 64'(reqReady), 64'd1);
    check(rdValid == 1'b0, "R1 rdValid", 64'(rdValid), 64'd0);
    check(done == 1'b0, "R1 done", 64'(done), 64'd0);

    scenario(0, 3, 1'b1, 1'b0);   // R2 upper quadrant, identifier ignored
    scenario(0, 3, 1'b0, 1'b0);   // R3, R6, R9 full depth
    scenario(0, 0, 1'b0, 1'b0);   // R9 leaf at the root level
    scenario(4, 0, 1'b0, 1'b0);   // R4
    scenario(5, 0, 1'b0, 1'b0);   // R5
    scenario(6, 2, 1'b0, 1'b0);   // R7
    scenario(7, 0, 1'b0, 1'b0);   // R8
    scenario(0, 2, 1'b0, 1'b1);   // R10 request offered while busy
    for (int k = 0; k < N_RANDOM; k++) begin
      int f;
      f = int'($urandom % 8);
      scenario(f < 4 ? 0 : f, int'($urandom % 4), 1'(($urandom % 2)), 1'(($urandom % 8) == 0));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule